// File: doc/BRIEF.md
# I2C Slave Mailbox Engine

This block is an I2C target that exchanges a small fixed-size mailbox with an external I2C master. It runs on a fast local clock and oversamples SCL and SDA through two-flop synchronizers. It detects START, repeated START and STOP, and compares the first byte of each transfer against a fixed 7-bit address. On a write, each data byte lands in the next slot of an inbound buffer. On a read, bytes are served from an outbound buffer. The slave pulls SDA low only to ACK or to send a zero; otherwise it leaves the line released.

The inbound buffer is twelve bytes, grouped as three 32-bit words. When a configurable number of inbound bytes has arrived in one transfer, a one-cycle event pulse goes to the local processor. At 48 MHz each 400 kHz SCL period spans about 120 clocks, so the three-cycle input latency fits well within the bus timing.

Top module: `i2c_mailbox_slave`

## Requirements
- R1: After reset, `sda_pull` and `rx_event` are low and `rx_words` is all zero.
- R2: When the address byte matches `SLAVE_ADDR` (bits 7:1 = address, bit 0 = 1 for read, 0 for write), the slave pulls SDA low during the ninth clock to ACK.
- R3: On an address mismatch, the slave does not ACK, stores nothing and leaves SDA released until the next START.
- R4: Write byte k of a transfer (counted from 0) is stored in `rx_words[8k+7:8k]`, so each 32-bit word fills least significant byte first. Slots that are not written keep their value.
- R5: Write bytes 0 to 11 are ACKed. Bytes beyond the twelfth are NACKed and discarded, and the byte index never passes 12.
- R6: `rx_event` is a single-cycle pulse that fires exactly once, when byte number `EVENT_COUNT` (1–12) of a write transfer is stored. A transfer with fewer bytes raises no pulse.
- R7: A read returns `tx_words[7:0]`, then `tx_words[15:8]`, and so on, each byte sent MSB first. Bytes past the twelfth read as 0xFF.
- R8: A master NACK ends the read. Later SCL pulses without a START see SDA released (they read 0xFF).
- R9: Every START or repeated START resets the byte index to 0, for both writes and reads.
- R10: After a STOP the slave ignores bus activity until a START, and SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock (48 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | I2C clock line |
| sda_in | input | 1 | I2C data line as seen on the wire |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| tx_words | input | 8*MAX_BYTES | Outbound bytes, byte k at bits 8k+7:8k |
| rx_words | output | 8*MAX_BYTES | Inbound bytes, byte k at bits 8k+7:8k |
| rx_event | output | 1 | One-cycle pulse when EVENT_COUNT bytes have arrived |

## Verification
The bench places two instances on one shared open-drain bus.

- The first instance uses the default address 0x3F and the default event count of 12. This lets the bench drive full-length and overflowing writes, where the event must coincide with the final slot.
- The second instance uses address 0x21 and an event count of 4. This puts the event on the last byte of word 0, in the middle of a longer transfer.

Because both instances share the bus, every transfer aimed at one of them is also a mismatch test for the other.

// File: rtl/i2c_mailbox_slave.sv
module i2c_mailbox_slave #(
  parameter logic [6:0] SLAVE_ADDR  = 7'h3F,
  parameter int         MAX_BYTES   = 12,
  parameter int         EVENT_COUNT = 12
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_in,
  input  logic                   sda_in,
  output logic                   sda_pull,
  input  logic [8*MAX_BYTES-1:0] tx_words,
  output logic [8*MAX_BYTES-1:0] rx_words,
  output logic                   rx_event
);
  localparam int IW = $clog2(MAX_BYTES + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(MAX_BYTES);
  localparam logic [IW-1:0] EV_IDX   = IW'(EVENT_COUNT);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ADDR_ACK, S_WR, S_WR_ACK, S_RD, S_RD_ACK} st_t;
  st_t st;

  logic [1:0] scl_sync, sda_sync;
  logic scl_q, sda_q, scl_s, sda_s;
  logic start_det, stop_det, scl_rise, scl_fall;
  logic [7:0] sr;
  logic [3:0] bitcnt;
  logic [IW-1:0] idx, idx_next;
  logic rw, m_ack;
  logic [7:0] cur_byte, nxt_byte;

  function automatic logic [7:0] byte_at(input logic [IW-1:0] i);
    byte_at = 8'hFF;
    for (int k = 0; k < MAX_BYTES; k++)
      if (i == IW'(k)) byte_at = tx_words[8*k +: 8];
  endfunction

  assign scl_s     = scl_sync[1];
  assign sda_s     = sda_sync[1];
  assign start_det = scl_q & scl_s & sda_q & ~sda_s;
  assign stop_det  = scl_q & scl_s & ~sda_q & sda_s;
  assign scl_rise  = ~scl_q & scl_s;
  assign scl_fall  = scl_q & ~scl_s;
  assign idx_next  = (idx < LAST_IDX) ? idx + 1'b1 : idx;
  assign cur_byte  = byte_at(idx);
  assign nxt_byte  = byte_at(idx_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sr       <= '0;
      bitcnt   <= '0;
      idx      <= '0;
      rw       <= 1'b0;
      m_ack    <= 1'b0;
      sda_pull <= 1'b0;
      rx_event <= 1'b0;
      rx_words <= '0;
    end else begin
      rx_event <= 1'b0;
      if (start_det) begin
        st       <= S_ADDR;
        bitcnt   <= '0;
        idx      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st       <= S_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          S_IDLE: ;
          S_ADDR:
            if (scl_rise) begin
              sr     <= {sr[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (sr[7:1] == SLAVE_ADDR) begin
                rw       <= sr[0];
                sda_pull <= 1'b1;
                st       <= S_ADDR_ACK;
              end else begin
                st <= S_IDLE;
              end
            end
          S_ADDR_ACK:
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                sr       <= cur_byte;
                sda_pull <= ~cur_byte[7];
                st       <= S_RD;
              end else begin
                sda_pull <= 1'b0;
                st       <= S_WR;
              end
            end
          S_WR:
            if (scl_rise) begin
              sr     <= {sr[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              st <= S_WR_ACK;
              if (idx < LAST_IDX) begin
                for (int k = 0; k < MAX_BYTES; k++)
                  if (idx == IW'(k)) rx_words[8*k +: 8] <= sr;
                idx      <= idx_next;
                sda_pull <= 1'b1;
                rx_event <= (idx_next == EV_IDX);
              end
            end
          S_WR_ACK:
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bitcnt   <= '0;
              st       <= S_WR;
            end
          S_RD:
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_pull <= 1'b0;
                st       <= S_RD_ACK;
              end else begin
                bitcnt   <= bitcnt + 4'd1;
                sr       <= {sr[6:0], 1'b1};
                sda_pull <= ~sr[6];
              end
            end
          S_RD_ACK:
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                idx      <= idx_next;
                sr       <= nxt_byte;
                sda_pull <= ~nxt_byte[7];
                bitcnt   <= '0;
                st       <= S_RD;
              end else begin
                st <= S_IDLE;
              end
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_IDX);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |=> !rx_event);
  a_r6_event_at_count: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |-> idx == EV_IDX);
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (idx == '0 && st == S_ADDR));
  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);
  a_r10_pull_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_s);
endmodule

// File: tb/test_i2c_mailbox_slave.sv
module test_i2c_mailbox_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 20;
  localparam logic [6:0] ADDR_A = 7'h3F;
  localparam logic [6:0] ADDR_B = 7'h21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic oe_a, oe_b, ev_a, ev_b;
  logic [95:0] rx_a, rx_b;
  logic [95:0] tx_a = 96'hA1B2C3D4_E5F60718_293A4B5C;
  logic [95:0] tx_b = 96'h01020304_05060708_090A0B0C;
  logic [95:0] exp_a = '0;
  logic [95:0] exp_b = '0;
  wire sda_bus = m_sda & ~oe_a & ~oe_b;
  int checks = 0, failures = 0, ev_cnt_a = 0, ev_cnt_b = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mailbox_slave i_i2c_mailbox_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_pull(oe_a),
    .tx_words(tx_a), .rx_words(rx_a), .rx_event(ev_a));

  i2c_mailbox_slave #(.SLAVE_ADDR(ADDR_B), .MAX_BYTES(12), .EVENT_COUNT(4)) i_i2c_mailbox_slave_b (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_pull(oe_b),
    .tx_words(tx_b), .rx_words(rx_b), .rx_event(ev_b));

  always @(posedge clk) begin
    if (ev_a) ev_cnt_a <= ev_cnt_a + 1;
    if (ev_b) ev_cnt_b <= ev_cnt_b + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; wt(Q/2);
    scl = 1'b1;   wt(Q);
    m_sda = 1'b0; wt(Q);
    scl = 1'b0;   wt(Q/2);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wt(Q/2);
    scl = 1'b1;   wt(Q);
    m_sda = 1'b1; wt(Q);
  endtask

  task automatic i2c_bit(input logic b, output logic r);
    m_sda = b; wt(Q/2);
    scl = 1'b1; wt(Q/2);
    r = sda_bus; wt(Q/2);
    scl = 1'b0; wt(Q/2);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) i2c_bit(d[i], r);
    i2c_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic ack_in, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      i2c_bit(1'b1, r);
      d[i] = r;
    end
    i2c_bit(~ack_in, r);
  endtask

  task automatic t_reset;
    chk(oe_a == 0 && oe_b == 0, "R1 sda_pull idle", {95'b0, oe_a}, 96'h0);
    chk(ev_cnt_a == 0 && ev_cnt_b == 0, "R1 no event", ev_cnt_a, 0);
    chk(rx_a == 0 && rx_b == 0, "R1 rx_words zero", rx_a, 96'h0);
  endtask

  task automatic t_full_write;
    logic ack;
    i2c_start;
    wr_byte({ADDR_A, 1'b0}, ack);
    chk(ack, "R2 address ack write", ack, 1);
    for (int k = 0; k < 12; k++) begin
      wr_byte(8'h40 + 8'(k), ack);
      chk(ack, "R5 byte ack", ack, 1);
      exp_a[8*k +: 8] = 8'h40 + 8'(k);
      if (k == 10) chk(ev_cnt_a == 0, "R6 no early event", ev_cnt_a, 0);
    end
    i2c_stop;
    chk(rx_a == exp_a, "R4 packing", rx_a, exp_a);
    chk(ev_cnt_a == 1, "R6 one event at 12", ev_cnt_a, 1);
    chk(rx_b == exp_b, "R3 other slave untouched", rx_b, exp_b);
    chk(ev_cnt_b == 0, "R3 other slave no event", ev_cnt_b, 0);
  endtask

  task automatic t_overflow;
    logic ack;
    i2c_start;
    wr_byte({ADDR_A, 1'b0}, ack);
    for (int k = 0; k < 14; k++) begin
      wr_byte(8'h80 + 8'(k), ack);
      if (k < 12) begin
        exp_a[8*k +: 8] = 8'h80 + 8'(k);
        chk(ack, "R5 ack within 12", ack, 1);
      end else begin
        chk(!ack, "R5 nack beyond 12", ack, 0);
      end
    end
    i2c_stop;
    chk(rx_a == exp_a, "R5 extra bytes discarded", rx_a, exp_a);
    chk(ev_cnt_a == 2, "R6 single event per transfer", ev_cnt_a, 2);
  endtask

  task automatic t_short;
    logic ack;
    i2c_start;
    wr_byte({ADDR_A, 1'b0}, ack);
    for (int k = 0; k < 3; k++) begin
      wr_byte(8'hC0 + 8'(k), ack);
      exp_a[8*k +: 8] = 8'hC0 + 8'(k);
    end
    i2c_stop;
    chk(rx_a == exp_a, "R4 partial write keeps rest", rx_a, exp_a);
    chk(ev_cnt_a == 2, "R6 short transfer no event", ev_cnt_a, 2);
  endtask

  task automatic t_b_event;
    logic ack;
    i2c_start;
    wr_byte({ADDR_B, 1'b0}, ack);
    chk(ack, "R2 address ack second slave", ack, 1);
    for (int k = 0; k < 5; k++) begin
      wr_byte(8'hD0 + 8'(k), ack);
      exp_b[8*k +: 8] = 8'hD0 + 8'(k);
      if (k == 2) chk(ev_cnt_b == 0, "R6 none before 4th", ev_cnt_b, 0);
      if (k == 3) chk(ev_cnt_b == 1, "R6 event on 4th", ev_cnt_b, 1);
      if (k == 4) chk(ev_cnt_b == 1, "R6 no second event", ev_cnt_b, 1);
    end
    i2c_stop;
    chk(rx_b == exp_b, "R4 second slave packing", rx_b, exp_b);
    chk(rx_a == exp_a, "R3 first slave untouched", rx_a, exp_a);
  endtask

  task automatic t_mismatch;
    logic ack;
    i2c_start;
    wr_byte({7'h55, 1'b0}, ack);
    chk(!ack, "R3 mismatch nack", ack, 0);
    wr_byte(8'h99, ack);
    chk(!ack, "R3 data after mismatch nack", ack, 0);
    i2c_stop;
    chk(rx_a == exp_a && rx_b == exp_b, "R3 nothing stored", rx_a, exp_a);
  endtask

  task automatic t_read;
    logic ack;
    logic [7:0] d;
    i2c_start;
    wr_byte({ADDR_A, 1'b1}, ack);
    chk(ack, "R2 address ack read", ack, 1);
    rd_byte(1'b1, d); chk(d == tx_a[7:0],   "R7 read byte 0", d, tx_a[7:0]);
    rd_byte(1'b1, d); chk(d == tx_a[15:8],  "R7 read byte 1", d, tx_a[15:8]);
    rd_byte(1'b0, d); chk(d == tx_a[23:16], "R7 read byte 2", d, tx_a[23:16]);
    rd_byte(1'b0, d); chk(d == 8'hFF, "R8 released after nack", d, 8'hFF);
    i2c_stop;
  endtask

  task automatic t_read_past_end;
    logic ack;
    logic [7:0] d;
    i2c_start;
    wr_byte({ADDR_A, 1'b1}, ack);
    for (int k = 0; k < 12; k++) rd_byte(1'b1, d);
    chk(d == tx_a[95:88], "R7 read byte 11", d, tx_a[95:88]);
    rd_byte(1'b0, d);
    chk(d == 8'hFF, "R7 past end reads FF", d, 8'hFF);
    i2c_stop;
  endtask

  task automatic t_repstart;
    logic ack;
    logic [7:0] d;
    i2c_start;
    wr_byte({ADDR_A, 1'b0}, ack);
    wr_byte(8'hE0, ack);
    wr_byte(8'hE1, ack);
    i2c_start;
    wr_byte({ADDR_A, 1'b0}, ack);
    chk(ack, "R9 ack after repeated start", ack, 1);
    wr_byte(8'hF0, ack);
    i2c_stop;
    exp_a[7:0] = 8'hF0;
    exp_a[15:8] = 8'hE1;
    chk(rx_a == exp_a, "R9 write index reset", rx_a, exp_a);
    i2c_start;
    wr_byte({ADDR_A, 1'b0}, ack);
    wr_byte(8'h11, ack);
    exp_a[7:0] = 8'h11;
    i2c_start;
    wr_byte({ADDR_A, 1'b1}, ack);
    rd_byte(1'b0, d);
    i2c_stop;
    chk(d == tx_a[7:0], "R9 read index reset", d, tx_a[7:0]);
    chk(rx_a == exp_a, "R9 write before restart", rx_a, exp_a);
  endtask

  task automatic t_stop_idle;
    logic ack;
    scl = 1'b0; wt(Q/2);
    wr_byte({ADDR_A, 1'b0}, ack);
    chk(!ack, "R10 no response without start", ack, 0);
    wr_byte(8'h77, ack);
    chk(!ack, "R10 data ignored without start", ack, 0);
    i2c_stop;
    chk(rx_a == exp_a, "R10 nothing stored", rx_a, exp_a);
  endtask

  initial begin
    wt(5);
    t_reset;
    rst_n = 1'b1;
    wt(5);
    t_full_write;
    t_overflow;
    t_short;
    t_b_event;
    t_mismatch;
    t_read;
    t_read_past_end;
    t_repstart;
    t_stop_idle;
    wt(10);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule